// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block supervises a CAN node's return from the bus-off state. Once an external error-handling unit signals bus-off entry, the block watches the sampled bus bits. It counts runs of eleven back-to-back recessive bits, and it decides when the node may take part in bus traffic again. When it decides, it issues a single-cycle rejoin pulse and drops its bus-off status in the same cycle.

Software can choose to keep the node off the bus by setting a hold input. The hold is captured only at the moment bus-off is entered. If hold is released before the full count of recovery runs has been seen, recovery finishes in the normal way. If hold is released after that count has been reached, the node first waits for one more run of eleven recessive bits before it rejoins. Raising hold while the node is already bus-off, when it was low at entry, does not affect the recovery in progress.

Top module: `boff_recovery`

## Requirements
- R1: After reset, `bus_off` is 0, `rejoin` is 0 and `seq_count` is 0.
- R2: While bus-off, each run of RUN_LEN (11) consecutive valid recessive bits (`bit_val` = 1 means recessive) raises `seq_count` by exactly one, and a new run then starts from zero. Cycles with `bit_vld` low have no effect on the run or on `seq_count`.
- R3: A valid dominant bit (`bit_val` = 0) resets the current run to zero and leaves `seq_count` unchanged.
- R4: If `hold_req` is low at entry, `rejoin` is asserted on the clock edge that completes run number SEQ_TARGET (128), and `bus_off` goes low in that same cycle.
- R5: `rejoin` is high for exactly one cycle per recovery.
- R6: `seq_count` saturates at SEQ_TARGET and never exceeds it.
- R7: If `hold_req` is high at entry, `bus_off` stays high for as long as `hold_req` stays high, whatever the bus shows.
- R8: If a hold captured at entry is released before SEQ_TARGET runs have been counted, recovery completes as in R4. This includes a release in the same cycle as the completing bit.
- R9: If a hold captured at entry is released after SEQ_TARGET runs have been counted, the run is restarted from zero. `rejoin` is then asserted on the edge that completes the next RUN_LEN consecutive recessive bits.
- R10: Raising `hold_req` after entry, when it was low at entry, does not delay the current recovery.
- R11: An entry pulse clears `seq_count` to 0 and sets `bus_off`. An entry pulse while `bus_off` is already high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe marking a new sampled bus bit |
| bit_val | input | 1 | Sampled bit, 1 = recessive, 0 = dominant |
| boff_enter | input | 1 | One-cycle pulse requesting bus-off entry |
| hold_req | input | 1 | Software request to suppress automatic recovery |
| bus_off | output | 1 | Node is in the bus-off state |
| rejoin | output | 1 | One-cycle pulse when the node rejoins the bus |
| seq_count | output | SEQ_W | Number of completed recessive runs, saturating |

## Verification
Two functions can fall in one cycle: releasing the hold and completing run number 128. A late-release rule applied here would wrongly add a resync run. The bench holds the node from entry, sends one bit short of the full count, and then drives the final recessive bit in the same cycle that `hold_req` falls. It expects `rejoin` and a low `bus_off` on that very edge. A second case releases the hold after saturation, with a partial run already under way. This shows that the earlier bits are not credited toward the resync run.

// File: rtl/boff_pkg.sv
package boff_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_OFF    = 2'd1,
    ST_RESYNC = 2'd2
  } boff_state_t;
endpackage

// File: rtl/boff_run_counter.sv
module boff_run_counter #(
  parameter int RUN_LEN = 11,
  localparam int RUN_W  = $clog2(RUN_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_val,
  output logic run_done
);
  logic [RUN_W-1:0] run_q, run_d;
  logic             run_last;

  assign run_last = (run_q == RUN_W'(RUN_LEN - 1));
  assign run_done = en && !clr && bit_vld && bit_val && run_last;

  always_comb begin
    run_d = run_q;
    if (clr || !en) begin
      run_d = '0;
    end else if (bit_vld) begin
      if (!bit_val)      run_d = '0;
      else if (run_last) run_d = '0;
      else               run_d = run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/boff_seq_counter.sv
module boff_seq_counter #(
  parameter int SEQ_TARGET = 128,
  localparam int SEQ_W     = $clog2(SEQ_TARGET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [SEQ_W-1:0] count,
  output logic             at_target,
  output logic             reach
);
  logic [SEQ_W-1:0] cnt_q, cnt_d;

  assign at_target = (cnt_q == SEQ_W'(SEQ_TARGET));
  assign reach     = inc && !clr && (cnt_q == SEQ_W'(SEQ_TARGET - 1));
  assign count     = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                   cnt_d = '0;
    else if (inc && !at_target) cnt_d = cnt_q + SEQ_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/boff_mode_ctrl.sv
module boff_mode_ctrl
  import boff_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic boff_enter,
  input  logic hold_req,
  input  logic run_done,
  input  logic reach,
  input  logic at_target,
  output logic entry,
  output logic run_clr,
  output logic counting,
  output logic bus_off,
  output logic rejoin
);
  boff_state_t st_q, st_d;
  logic        hold_q, hold_d;
  logic        rejoin_d;
  logic        late_rel;

  assign entry    = (st_q == ST_ACTIVE) && boff_enter;
  assign late_rel = (st_q == ST_OFF) && hold_q && !hold_req && at_target;
  assign run_clr  = entry || late_rel;
  assign counting = (st_q != ST_ACTIVE);

  always_comb begin
    st_d     = st_q;
    hold_d   = hold_q && hold_req;
    rejoin_d = 1'b0;
    unique case (st_q)
      ST_ACTIVE: begin
        if (boff_enter) begin
          st_d   = ST_OFF;
          hold_d = hold_req;
        end
      end
      ST_OFF: begin
        if (late_rel) begin
          st_d = ST_RESYNC;
        end else if (reach && !(hold_q && hold_req)) begin
          st_d     = ST_ACTIVE;
          rejoin_d = 1'b1;
        end
      end
      ST_RESYNC: begin
        if (run_done) begin
          st_d     = ST_ACTIVE;
          rejoin_d = 1'b1;
        end
      end
      default: st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ACTIVE;
      hold_q <= 1'b0;
      rejoin <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
      rejoin <= rejoin_d;
    end
  end

  assign bus_off = (st_q != ST_ACTIVE);
endmodule

// File: rtl/boff_recovery.sv
module boff_recovery #(
  parameter int RUN_LEN    = 11,
  parameter int SEQ_TARGET = 128,
  localparam int SEQ_W     = $clog2(SEQ_TARGET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             boff_enter,
  input  logic             hold_req,
  output logic             bus_off,
  output logic             rejoin,
  output logic [SEQ_W-1:0] seq_count
);
  logic entry, run_clr, counting, run_done, reach, at_target;

  boff_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (counting),
    .clr      (run_clr),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .run_done (run_done)
  );

  boff_seq_counter #(.SEQ_TARGET(SEQ_TARGET)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (entry),
    .inc       (run_done),
    .count     (seq_count),
    .at_target (at_target),
    .reach     (reach)
  );

  boff_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .boff_enter (boff_enter),
    .hold_req   (hold_req),
    .run_done   (run_done),
    .reach      (reach),
    .at_target  (at_target),
    .entry      (entry),
    .run_clr    (run_clr),
    .counting   (counting),
    .bus_off    (bus_off),
    .rejoin     (rejoin)
  );
endmodule

// File: rtl/boff_recovery_chk.sv
module boff_recovery_chk #(
  parameter int SEQ_TARGET = 128,
  localparam int SEQ_W     = $clog2(SEQ_TARGET + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic             bit_val,
  input logic             bus_off,
  input logic             rejoin,
  input logic [SEQ_W-1:0] seq_count
);
  assert_rejoin_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rejoin |=> !rejoin);

  assert_rejoin_drops_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rejoin |-> (!bus_off && $past(bus_off)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_count <= SEQ_W'(SEQ_TARGET));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && $past(bus_off)) |->
      (seq_count == $past(seq_count) || seq_count == $past(seq_count) + SEQ_W'(1)));

  assert_dominant_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && bit_vld && !bit_val) |=> $stable(seq_count));

  assert_entry_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> (seq_count == '0));
endmodule

bind boff_recovery boff_recovery_chk #(.SEQ_TARGET(SEQ_TARGET)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_vld   (bit_vld),
  .bit_val   (bit_val),
  .bus_off   (bus_off),
  .rejoin    (rejoin),
  .seq_count (seq_count)
);

// File: tb/tb_boff_recovery.sv
module tb_boff_recovery;
  localparam int RUN_LEN    = 11;
  localparam int SEQ_TARGET = 128;
  localparam int SEQ_W      = $clog2(SEQ_TARGET + 1);
  localparam int FULL       = RUN_LEN * SEQ_TARGET;

  logic clk, rst_n, bit_vld, bit_val, boff_enter, hold_req;
  logic bus_off, rejoin;
  logic [SEQ_W-1:0] seq_count;
  int n_run, n_fail;
  bit done;

  boff_recovery #(.RUN_LEN(RUN_LEN), .SEQ_TARGET(SEQ_TARGET)) dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .boff_enter(boff_enter), .hold_req(hold_req),
    .bus_off(bus_off), .rejoin(rejoin), .seq_count(seq_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_bits(int n, logic v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_val = v;
    end
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic enter(logic h);
    @(negedge clk); boff_enter = 1'b1; hold_req = h;
    @(negedge clk); boff_enter = 1'b0;
    check("R11 entry sets bus_off", bus_off, 1);
    check("R11 entry clears count", seq_count, 0);
  endtask

  task automatic t_reset();
    check("R1 bus_off", bus_off, 0);
    check("R1 rejoin", rejoin, 0);
    check("R1 seq_count", seq_count, 0);
  endtask

  task automatic t_auto();
    enter(1'b0);
    send_bits(FULL - 1, 1'b1);
    check("R4 still off", bus_off, 1);
    check("R2 count 127", seq_count, SEQ_TARGET - 1);
    send_bits(1, 1'b1);
    check("R4 rejoin", rejoin, 1);
    check("R4 bus_off low", bus_off, 0);
    check("R6 count at target", seq_count, SEQ_TARGET);
    @(negedge clk);
    check("R5 pulse ends", rejoin, 0);
  endtask

  task automatic t_runs();
    enter(1'b0);
    send_bits(10, 1'b1);
    @(negedge clk); bit_vld = 1'b0; bit_val = 1'b1;
    @(negedge clk);
    check("R2 idle strobe no count", seq_count, 0);
    send_bits(1, 1'b0);
    send_bits(10, 1'b1);
    check("R3 dominant restarts run", seq_count, 0);
    send_bits(1, 1'b1);
    check("R2 one run", seq_count, 1);
    @(negedge clk); boff_enter = 1'b1; hold_req = 1'b0;
    @(negedge clk); boff_enter = 1'b0;
    check("R11 re-entry ignored", seq_count, 1);
    send_bits(FULL - RUN_LEN, 1'b1);
    check("R4 rejoin after runs", rejoin, 1);
  endtask

  task automatic t_late();
    enter(1'b1);
    send_bits(FULL + 2 * RUN_LEN, 1'b1);
    check("R7 held", bus_off, 1);
    check("R6 saturated", seq_count, SEQ_TARGET);
    send_bits(5, 1'b1);
    @(negedge clk); hold_req = 1'b0;
    @(negedge clk);
    check("R9 no rejoin on release", bus_off, 1);
    send_bits(RUN_LEN - 1, 1'b1);
    check("R9 waits full run", bus_off, 1);
    send_bits(1, 1'b1);
    check("R9 rejoin after resync", rejoin, 1);
    check("R9 bus_off low", bus_off, 0);
  endtask

  task automatic t_early();
    enter(1'b1);
    send_bits(50 * RUN_LEN, 1'b1);
    hold_req = 1'b0;
    send_bits(FULL - 50 * RUN_LEN - 1, 1'b1);
    check("R8 not yet", bus_off, 1);
    send_bits(1, 1'b1);
    check("R8 early release rejoin", rejoin, 1);
  endtask

  task automatic t_same_cycle();
    enter(1'b1);
    send_bits(FULL - 1, 1'b1);
    check("R7 held before final", bus_off, 1);
    @(negedge clk); bit_vld = 1'b1; bit_val = 1'b1; hold_req = 1'b0;
    @(negedge clk); bit_vld = 1'b0;
    check("R8 same-cycle release rejoin", rejoin, 1);
    check("R8 same-cycle bus_off", bus_off, 0);
  endtask

  task automatic t_late_set();
    enter(1'b0);
    send_bits(20 * RUN_LEN, 1'b1);
    hold_req = 1'b1;
    send_bits(FULL - 20 * RUN_LEN, 1'b1);
    check("R10 late hold ignored", rejoin, 1);
    check("R10 bus_off low", bus_off, 0);
    @(negedge clk); hold_req = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bit_vld = 1'b0; bit_val = 1'b1; boff_enter = 1'b0; hold_req = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_auto();
    t_runs();
    t_late();
    t_early();
    t_same_cycle();
    t_late_set();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule